// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block decides which pending serial-port interrupt is shown to the host and drives the single interrupt request line. Some sources are pulse events, and the block holds them until each one's own clearing action: line-status errors, receive timeout and transmit-holding-empty. Other sources are levels sampled on every cycle: the receive FIFO fill against its trigger, and the modem-change flag. An enable register masks each source. A fixed priority picks the one source to report.

The host reads an 8-bit identification value. Bit 0 is low when an interrupt is pending. Bits 3:1 carry the source code, and bits 7:6 show whether the FIFOs are enabled. The same enabled-and-pending condition is registered to form the interrupt output. The FIFOs, the serializer, the baud generator and the bus decode sit outside the block. They supply their status as event pulses, levels and read/write strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: Out of reset, and whenever no enabled source is pending with the FIFOs enabled, the identification value is 0xC1 and the interrupt output is low.
- R2: The low nibble of the identification value reports the source: 0x6 for line status, 0x4 for receive data, 0xC for receive timeout, 0x2 for transmit empty and 0x0 for modem change. Bits 5:4 always read 0.
- R3: Enable bit 0 gates both receive data and timeout, bit 1 gates transmit empty, bit 2 gates line status and bit 3 gates modem change. A disabled source is neither reported nor drives the interrupt. Its pending state is kept, and it is reported as soon as it is enabled.
- R4: Priority runs from highest to lowest: line status, receive data, receive timeout, transmit empty, modem change. Only the highest enabled pending source is encoded.
- R5: A line-status event pulse makes that source pending. A line-status register read clears it. If an event and a read fall in the same cycle, the source stays pending.
- R6: Receive data is pending while the FIFO level is nonzero and at or above the trigger level. It stops being pending once the level drops below the trigger.
- R7: A timeout event pulse makes the timeout source pending. A receive-buffer read clears it.
- R8: A transmit-empty event pulse makes that source pending. Two things clear it: a transmit-holding write, or an identification read in a cycle when the identification value shows 0x2. An identification read while another code is shown leaves it pending. If an event and a clear fall in the same cycle, the source stays pending.
- R9: Modem change is reported for as long as the modem-change input is high.
- R10: Bits 7:6 of the identification value both equal the FIFO-enable input.
- R11: The interrupt output is a register. After each clock edge it is high exactly when the identification value, formed from the state just latched and the current inputs, shows a pending source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 4 | Interrupt enable bits (see R3) |
| fifo_en_i | input | 1 | FIFOs enabled; drives bits 7:6 of the identification value |
| ls_event_i | input | 1 | Line-status error event pulse |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive FIFO trigger level |
| timeout_evt_i | input | 1 | Receive character-timeout event pulse |
| thr_empty_evt_i | input | 1 | Transmit holding register became empty (pulse) |
| thr_write_i | input | 1 | Host write to the transmit holding register |
| modem_chg_i | input | 1 | Modem status change flag (level) |
| rd_iir_i | input | 1 | Host read of the identification register |
| rd_lsr_i | input | 1 | Host read of the line-status register |
| rd_rbr_i | input | 1 | Host read of the receive buffer |
| iir_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request line |

## Verification
Two collisions need care. The first is an identification read that clears transmit-empty while a line-status event arrives in the same cycle. The bench drives both strobes together and then expects 0xC6 with transmit-empty gone. A following line-status read must then leave 0xC1. The second is a set pulse meeting a clear strobe for the same source in one cycle. This is provoked for line status and for transmit empty, and in each case the source must still be reported in the next cycle. A further case is an identification read made while a higher code hides transmit empty. The bench checks that transmit empty reappears once the receive level falls below the trigger.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // enable register bit positions
    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;
    localparam int EN_W  = 4;

    localparam int IIR_W = 8;

    // latched (event-driven) source slots
    localparam int LAT_LINE = 0;
    localparam int LAT_TMO  = 1;
    localparam int LAT_TX   = 2;
    localparam int NUM_LAT  = 3;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1,
        ID_TXEMPTY = 4'h2,
        ID_RXDATA  = 4'h4,
        ID_LINE    = 4'h6,
        ID_RXTMO   = 4'hC
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic rxtmo;
        logic txempty;
        logic modem;
    } src_vec_t;

    localparam int SRC_W = $bits(src_vec_t);

    function automatic src_vec_t mask_src(src_vec_t p, logic [EN_W-1:0] en);
        src_vec_t m;
        m.line    = p.line    & en[EN_LS];
        m.rxdata  = p.rxdata  & en[EN_RX];
        m.rxtmo   = p.rxtmo   & en[EN_RX];
        m.txempty = p.txempty & en[EN_TX];
        m.modem   = p.modem   & en[EN_MS];
        return m;
    endfunction

    function automatic irq_id_e pick_id(src_vec_t a);
        if (a.line)         return ID_LINE;
        else if (a.rxdata)  return ID_RXDATA;
        else if (a.rxtmo)   return ID_RXTMO;
        else if (a.txempty) return ID_TXEMPTY;
        else if (a.modem)   return ID_MODEM;
        else                return ID_NONE;
    endfunction

endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o,
    output logic nxt_o
);
    // a new event in the clearing cycle is not lost
    assign nxt_o = set_i | (q_o & ~clr_i);

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= nxt_o;
    end
endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ls_event_i,
    input  logic             timeout_evt_i,
    input  logic             thr_empty_evt_i,
    input  logic             thr_write_i,
    input  logic             rd_lsr_i,
    input  logic             rd_rbr_i,
    input  logic             rd_iir_i,
    input  irq_id_e          cur_id_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] rx_trig_i,
    input  logic             modem_chg_i,
    output src_vec_t         pend_o,
    output src_vec_t         pend_nxt_o
);
    logic [NUM_LAT-1:0] set_v, clr_v, q_v, nxt_v;
    logic               rx_ok;

    always_comb begin
        set_v[LAT_LINE] = ls_event_i;
        clr_v[LAT_LINE] = rd_lsr_i;
        set_v[LAT_TMO]  = timeout_evt_i;
        clr_v[LAT_TMO]  = rd_rbr_i;
        set_v[LAT_TX]   = thr_empty_evt_i;
        clr_v[LAT_TX]   = thr_write_i | (rd_iir_i && cur_id_i == ID_TXEMPTY);
    end

    for (genvar g = 0; g < NUM_LAT; g++) begin : g_lat
        uart_irq_latch u_lat (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (q_v[g]),
            .nxt_o (nxt_v[g])
        );
    end

    assign rx_ok = (rx_level_i != '0) && (rx_level_i >= rx_trig_i);

    always_comb begin
        pend_o.line    = q_v[LAT_LINE];
        pend_o.rxdata  = rx_ok;
        pend_o.rxtmo   = q_v[LAT_TMO];
        pend_o.txempty = q_v[LAT_TX];
        pend_o.modem   = modem_chg_i;

        pend_nxt_o.line    = nxt_v[LAT_LINE];
        pend_nxt_o.rxdata  = rx_ok;
        pend_nxt_o.rxtmo   = nxt_v[LAT_TMO];
        pend_nxt_o.txempty = nxt_v[LAT_TX];
        pend_nxt_o.modem   = modem_chg_i;
    end
endmodule

// File: rtl/uart_irq_select.sv
module uart_irq_select
    import uart_irq_pkg::*;
(
    input  src_vec_t          pend_i,
    input  logic [EN_W-1:0]   ier_i,
    input  logic              fifo_en_i,
    output irq_id_e           id_o,
    output logic [IIR_W-1:0]  iir_o
);
    src_vec_t masked;

    always_comb begin
        masked = mask_src(pend_i, ier_i);
        id_o   = pick_id(masked);
        iir_o  = {{2{fifo_en_i}}, 2'b00, id_o};
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EN_W-1:0]   ier_i,
    input  logic              fifo_en_i,
    input  logic              ls_event_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic [LVL_W-1:0]  rx_trig_i,
    input  logic              timeout_evt_i,
    input  logic              thr_empty_evt_i,
    input  logic              thr_write_i,
    input  logic              modem_chg_i,
    input  logic              rd_iir_i,
    input  logic              rd_lsr_i,
    input  logic              rd_rbr_i,
    output logic [IIR_W-1:0]  iir_o,
    output logic              irq_o
);
    src_vec_t          pend, pend_nxt;
    irq_id_e           cur_id;
    logic [SRC_W-1:0]  nxt_en_bits;

    uart_irq_pending #(.LVL_W(LVL_W)) u_pend (
        .clk             (clk),
        .rst             (rst),
        .ls_event_i      (ls_event_i),
        .timeout_evt_i   (timeout_evt_i),
        .thr_empty_evt_i (thr_empty_evt_i),
        .thr_write_i     (thr_write_i),
        .rd_lsr_i        (rd_lsr_i),
        .rd_rbr_i        (rd_rbr_i),
        .rd_iir_i        (rd_iir_i),
        .cur_id_i        (cur_id),
        .rx_level_i      (rx_level_i),
        .rx_trig_i       (rx_trig_i),
        .modem_chg_i     (modem_chg_i),
        .pend_o          (pend),
        .pend_nxt_o      (pend_nxt)
    );

    uart_irq_select u_sel (
        .pend_i    (pend),
        .ier_i     (ier_i),
        .fifo_en_i (fifo_en_i),
        .id_o      (cur_id),
        .iir_o     (iir_o)
    );

    // register the line from the state being latched so it lines up with iir_o
    assign nxt_en_bits = mask_src(pend_nxt, ier_i);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |nxt_en_bits;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       ier_i,
    input logic             fifo_en_i,
    input logic             ls_event_i,
    input logic [LVL_W-1:0] rx_level_i,
    input logic [LVL_W-1:0] rx_trig_i,
    input logic             timeout_evt_i,
    input logic             thr_empty_evt_i,
    input logic             thr_write_i,
    input logic             modem_chg_i,
    input logic             rd_lsr_i,
    input logic             rd_rbr_i,
    input logic [3:0]       id_nib,
    input logic             irq_o
);
    AST_LS_ON_TOP: assert property (@(posedge clk) disable iff (rst)
        ier_i[2] && ls_event_i |=> (!ier_i[2] || id_nib == 4'h6)); // R4

    AST_LS_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_lsr_i && !ls_event_i |=> id_nib != 4'h6); // R5

    AST_TMO_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_rbr_i && !timeout_evt_i |=> id_nib != 4'hC); // R7

    AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        thr_write_i && !thr_empty_evt_i |=> id_nib != 4'h2); // R8

    AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
        !ier_i[0] |-> (id_nib != 4'h4 && id_nib != 4'hC)); // R3

    AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $stable(ier_i) && $stable(rx_level_i) && $stable(rx_trig_i)
        && $stable(modem_chg_i) && $stable(fifo_en_i)
        |-> irq_o == !id_nib[0]); // R11
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ier_i           (ier_i),
    .fifo_en_i       (fifo_en_i),
    .ls_event_i      (ls_event_i),
    .rx_level_i      (rx_level_i),
    .rx_trig_i       (rx_trig_i),
    .timeout_evt_i   (timeout_evt_i),
    .thr_empty_evt_i (thr_empty_evt_i),
    .thr_write_i     (thr_write_i),
    .modem_chg_i     (modem_chg_i),
    .rd_lsr_i        (rd_lsr_i),
    .rd_rbr_i        (rd_rbr_i),
    .id_nib          (iir_o[3:0]),
    .irq_o           (irq_o)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 5;
    localparam int WD_LIMIT   = 5000;

    typedef struct packed {
        logic [3:0]       ier;
        logic             fen;
        logic             ls;
        logic [LVL_W-1:0] lvl;
        logic [LVL_W-1:0] trig;
        logic             to;
        logic             te;
        logic             tw;
        logic             ms;
        logic             ri;
        logic             rl;
        logic             rr;
        logic [7:0]       exp;
        logic [3:0]       req;
    } row_t;

    localparam int NROWS = 33;
    //  ier  fen ls lvl trig to te tw ms ri rl rr exp req
    localparam row_t ROWS [NROWS] = '{
        '{4'h0,1,0,5'd0,5'd1,0,0,0,0,0,0,0,8'hC1,4'd1},  // R1 idle
        '{4'hF,1,1,5'd0,5'd1,0,0,0,0,0,0,0,8'hC6,4'd5},  // R5 line event
        '{4'hF,1,0,5'd0,5'd1,0,1,0,0,0,0,0,8'hC6,4'd4},  // R4 line over tx
        '{4'hF,1,0,5'd0,5'd1,0,0,0,0,0,1,0,8'hC2,4'd5},  // R5 lsr read clears
        '{4'hF,1,0,5'd4,5'd4,0,0,0,0,0,0,0,8'hC4,4'd6},  // R6 level at trigger
        '{4'hF,1,0,5'd3,5'd4,0,0,0,0,0,0,0,8'hC2,4'd6},  // R6 below trigger
        '{4'hF,1,0,5'd0,5'd4,1,0,0,0,0,0,0,8'hCC,4'd7},  // R7 timeout
        '{4'hF,1,0,5'd4,5'd4,0,0,0,0,0,0,0,8'hC4,4'd4},  // R4 data over timeout
        '{4'hF,1,0,5'd0,5'd4,0,0,0,0,0,0,1,8'hC2,4'd7},  // R7 rbr read clears
        '{4'hF,1,0,5'd0,5'd1,0,0,0,0,1,0,0,8'hC1,4'd8},  // R8 iir read clears tx
        '{4'hF,1,0,5'd0,5'd1,0,1,0,0,0,0,0,8'hC2,4'd2},  // R2 tx code
        '{4'hF,1,0,5'd0,5'd1,0,0,1,0,0,0,0,8'hC1,4'd8},  // R8 thr write clears
        '{4'hF,1,0,5'd0,5'd1,0,1,0,1,0,0,0,8'hC2,4'd4},  // R4 tx over modem
        '{4'hF,1,0,5'd0,5'd1,0,0,1,1,0,0,0,8'hC0,4'd9},  // R9 modem code 0
        '{4'h0,1,0,5'd0,5'd1,0,0,0,1,0,0,0,8'hC1,4'd3},  // R3 modem gated
        '{4'h0,1,1,5'd0,5'd1,0,0,0,0,0,0,0,8'hC1,4'd3},  // R3 line gated
        '{4'h4,1,0,5'd0,5'd1,0,0,0,0,0,0,0,8'hC6,4'd3},  // R3 kept, shown on enable
        '{4'h4,0,0,5'd0,5'd1,0,0,0,0,0,0,0,8'h06,4'd10}, // R10 fifo off
        '{4'h4,0,1,5'd0,5'd1,0,0,0,0,0,1,0,8'h06,4'd5},  // R5 set wins over read
        '{4'h4,1,0,5'd0,5'd1,0,0,0,0,0,1,0,8'hC1,4'd5},  // R5 read clears
        '{4'h2,1,0,5'd0,5'd1,0,1,0,0,0,0,0,8'hC2,4'd8},  // R8 tx pending
        '{4'h6,1,1,5'd0,5'd1,0,0,0,0,1,0,0,8'hC6,4'd8},  // R8 iir read + line event
        '{4'h6,1,0,5'd0,5'd1,0,0,0,0,0,1,0,8'hC1,4'd8},  // R8 tx was cleared
        '{4'h7,1,0,5'd2,5'd1,0,1,0,0,0,0,0,8'hC4,4'd6},  // R6 data hides tx
        '{4'h7,1,0,5'd2,5'd1,0,0,0,0,1,0,0,8'hC4,4'd8},  // R8 read of other code
        '{4'h7,1,0,5'd0,5'd1,0,0,0,0,0,0,0,8'hC2,4'd8},  // R8 tx still pending
        '{4'h7,1,0,5'd0,5'd1,0,1,1,0,0,0,0,8'hC2,4'd8},  // R8 set wins over write
        '{4'h7,1,0,5'd0,5'd1,0,0,1,0,0,0,0,8'hC1,4'd8},  // R8 write clears
        '{4'h1,1,0,5'd0,5'd0,0,0,0,0,0,0,0,8'hC1,4'd6},  // R6 zero level ignored
        '{4'h1,1,0,5'd0,5'd0,1,0,0,0,0,0,0,8'hCC,4'd7},  // R7 timeout
        '{4'h0,1,0,5'd0,5'd0,0,0,0,0,0,0,0,8'hC1,4'd3},  // R3 bit0 gates timeout
        '{4'h1,1,0,5'd0,5'd0,0,0,0,0,0,0,0,8'hCC,4'd3},  // R3 timeout kept
        '{4'h1,1,0,5'd0,5'd0,0,0,0,0,0,0,1,8'hC1,4'd7}   // R7 read clears
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       ier_i = '0;
    logic             fifo_en_i = 1'b1;
    logic             ls_event_i = 1'b0;
    logic [LVL_W-1:0] rx_level_i = '0;
    logic [LVL_W-1:0] rx_trig_i = 5'd1;
    logic             timeout_evt_i = 1'b0;
    logic             thr_empty_evt_i = 1'b0;
    logic             thr_write_i = 1'b0;
    logic             modem_chg_i = 1'b0;
    logic             rd_iir_i = 1'b0;
    logic             rd_lsr_i = 1'b0;
    logic             rd_rbr_i = 1'b0;
    logic [7:0]       iir_o;
    logic             irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident #(.LVL_W(LVL_W)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .ier_i           (ier_i),
        .fifo_en_i       (fifo_en_i),
        .ls_event_i      (ls_event_i),
        .rx_level_i      (rx_level_i),
        .rx_trig_i       (rx_trig_i),
        .timeout_evt_i   (timeout_evt_i),
        .thr_empty_evt_i (thr_empty_evt_i),
        .thr_write_i     (thr_write_i),
        .modem_chg_i     (modem_chg_i),
        .rd_iir_i        (rd_iir_i),
        .rd_lsr_i        (rd_lsr_i),
        .rd_rbr_i        (rd_rbr_i),
        .iir_o           (iir_o),
        .irq_o           (irq_o)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD_LIMIT) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cycles, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp,
                         input int req, input string what);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL R%0d %s: act=0x%02h exp=0x%02h", req, what, act, exp);
        end
    endtask

    task automatic apply(input row_t r);
        ier_i           = r.ier;
        fifo_en_i       = r.fen;
        ls_event_i      = r.ls;
        rx_level_i      = r.lvl;
        rx_trig_i       = r.trig;
        timeout_evt_i   = r.to;
        thr_empty_evt_i = r.te;
        thr_write_i     = r.tw;
        modem_chg_i     = r.ms;
        rd_iir_i        = r.ri;
        rd_lsr_i        = r.rl;
        rd_rbr_i        = r.rr;
    endtask

    initial begin
        row_t idle;
        idle = '{4'h0,1'b1,1'b0,5'd0,5'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hC1,4'd1};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(iir_o, 8'hC1, 1, "reset iir");
        check({7'd0, irq_o}, 8'd0, 1, "reset irq");

        for (int i = 0; i < NROWS; i++) begin
            apply(ROWS[i]);
            @(negedge clk);
            check(iir_o, ROWS[i].exp, int'(ROWS[i].req), $sformatf("row %0d iir", i));
            // R11 line follows the pending indication
            check({7'd0, irq_o}, {7'd0, ~ROWS[i].exp[0]}, 11, $sformatf("row %0d irq", i));
        end

        // R1 directed: reset drops a pending line-status interrupt
        apply(idle);
        ier_i = 4'h4; ls_event_i = 1'b1;
        @(negedge clk);
        ls_event_i = 1'b0;
        check(iir_o, 8'hC6, 5, "line before reset");
        check({7'd0, irq_o}, 8'd1, 11, "irq before reset");
        rst = 1'b1;
        @(negedge clk);
        check(iir_o, 8'hC1, 1, "iir in reset");
        check({7'd0, irq_o}, 8'd0, 1, "irq in reset");
        rst = 1'b0;
        @(negedge clk);
        check(iir_o, 8'hC1, 1, "iir after reset");

        // R2 directed: upper nibble bits 5:4 stay clear under every code
        apply(idle);
        ier_i = 4'hF; thr_empty_evt_i = 1'b1;
        @(negedge clk);
        thr_empty_evt_i = 1'b0;
        check({6'd0, iir_o[5:4]}, 8'd0, 2, "bits 5:4");
        thr_write_i = 1'b1;
        @(negedge clk);
        thr_write_i = 1'b0;
        check(iir_o, 8'hC1, 8, "final clear");

        summary();
        $finish;
    end
endmodule